// File: doc/BRIEF.md
# SONET Path Pointer Interpreter

This block follows the path pointer carried in the H1/H2 overhead bytes of an STS-1 signal. Once per frame an upstream framer presents the 16-bit pointer word together with a one-cycle strobe. The block sorts each word into one event class: AIS, out of range, new data flag, normal, increment, decrement, candidate or confirmed new value. It keeps the accepted pointer offset and runs a two-state loss-of-pointer machine.

Each event class owns a sticky status bit that a host read clears. A per-bit mask combines the status bits into one interrupt line. A one-bit read select exposes either the status bits, or the accepted pointer together with the loss-of-pointer flag.

The machine has two states. In ST_LOSS no pointer is accepted. It moves to ST_SYNC on the transition named "confirm", which takes three equal in-range pointers. In ST_SYNC a pointer is tracked. It falls back to ST_LOSS on the transition named "declare", which takes eight consecutive invalid words or eight consecutive new-data-flag words. Both transitions raise the loss-of-pointer change event.

Top module: `ptr_interp`

## Requirements
- R1: The status bits are sticky and clear when a read with `rd_sel`=0 is made. An event that arrives in the same cycle as that read is kept for the next read.
- R2: `irq` is high exactly when some status bit is set and its bit in `ev_mask` is also set.
- R3: The flag field is bits 15:12 of the word. It counts as enabled when at least 3 of its 4 bits match 1001. An enabled flag with an in-range value sets status bit 2 and never bit 6. In ST_SYNC it also loads the value as the accepted pointer at once.
- R4: An increment is seen when at least 3 of the 5 I bits (positions 9,7,5,3,1) differ from the accepted pointer and fewer than 3 D bits do. It sets status bit 3 and adds one to the accepted pointer.
- R5: A decrement is seen the same way on the D bits (positions 8,6,4,2,0). It sets status bit 4 and subtracts one from the accepted pointer.
- R6: An all-ones word sets status bit 0 and leaves the accepted pointer unchanged.
- R7: An in-range value that differs from the accepted pointer, and is neither increment nor decrement, becomes accepted on its third equal frame in a row. That frame sets status bit 6. The earlier frames of the run each set status bit 5.
- R8: A pointer value above 782 is invalid and sets status bit 5. A value of 782 is in range.
- R9: In ST_SYNC, eight consecutive invalid frames, or eight consecutive flag frames, move the block to ST_LOSS and set status bit 1. Status bit 5 frames count as invalid.
- R10: In ST_LOSS, three equal in-range non-flag pointers move the block to ST_SYNC. That frame sets status bits 6 and 1.
- R11: After reset the status is 0, the state is ST_LOSS and the accepted pointer is 0. `rd_data` is loaded one cycle after `rd_en`. With `rd_sel`=0 it holds the status in bits 6:0. With `rd_sel`=1 it holds the loss flag in bit 10 and the pointer in bits 9:0. All other bits are 0.
- R12: A non-flag word equal to the accepted pointer raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-cycle strobe, marks the pointer word of a frame |
| ptr_word | input | 16 | H1/H2 pointer word |
| ev_mask | input | 7 | Interrupt enable, one bit for each status bit |
| rd_en | input | 1 | Read request |
| rd_sel | input | 1 | 0 reads the status bits (and clears them), 1 reads the pointer and loss flag |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Masked OR of the status bits |

## Verification
The bench builds the block with its default parameters. These are a 10-bit offset with a limit of 782, a three-frame confirm run, and declare counts of eight. With these values both declare paths, the recovery path and the 782 boundary are reached in a few dozen frames. The counts are small enough that every frame of a run can be read back and checked one by one, including the frames just before a transition.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
    typedef enum logic {
        ST_LOSS = 1'b0,
        ST_SYNC = 1'b1
    } lop_state_e;

    localparam int EVW    = 7;
    localparam int EV_AIS = 0;
    localparam int EV_LOPC = 1;
    localparam int EV_NDF = 2;
    localparam int EV_INC = 3;
    localparam int EV_DEC = 4;
    localparam int EV_UNK = 5;
    localparam int EV_NEW = 6;
endpackage

// File: rtl/ptr_word_decode.sv
module ptr_word_decode #(
    parameter int PTR_W   = 10,
    parameter int NDF_W   = 4,
    parameter int SS_W    = 2,
    parameter int PTR_MAX = 782,
    parameter logic [NDF_W-1:0] NDF_PAT = 4'b1001
) (
    input  logic [NDF_W+SS_W+PTR_W-1:0] word,
    input  logic [PTR_W-1:0]            acc,
    output logic                        ndf_on,
    output logic                        is_ais,
    output logic                        in_range,
    output logic                        inc_hit,
    output logic                        dec_hit,
    output logic [PTR_W-1:0]            val
);
    localparam int WW    = NDF_W + SS_W + PTR_W;
    localparam int NI    = (PTR_W + 1) / 2;
    localparam int THR   = NI / 2 + 1;
    localparam int NDF_T = NDF_W - 1;
    localparam logic [PTR_W-1:0] MAXV = PTR_W'(PTR_MAX);

    logic [PTR_W-1:0] i_sel;
    logic [PTR_W-1:0] diff;
    logic [NDF_W-1:0] nfield;
    int               i_cnt;
    int               d_cnt;
    int               n_cnt;

    // I positions start at the top bit and alternate downward
    for (genvar b = 0; b < PTR_W; b++) begin : g_isel
        assign i_sel[b] = (((PTR_W - 1 - b) % 2) == 0);
    end

    assign val    = word[PTR_W-1:0];
    assign nfield = word[WW-1:WW-NDF_W];
    assign diff   = val ^ acc;

    always_comb begin
        i_cnt    = $countones(diff & i_sel);
        d_cnt    = $countones(diff & ~i_sel);
        n_cnt    = $countones(~(nfield ^ NDF_PAT));
        ndf_on   = (n_cnt >= NDF_T);
        is_ais   = &word;
        in_range = (val <= MAXV);
        inc_hit  = (i_cnt >= THR) && (d_cnt < THR);
        dec_hit  = (d_cnt >= THR) && (i_cnt < THR);
    end
endmodule

// File: rtl/ptr_track_fsm.sv
module ptr_track_fsm
    import ptr_pkg::*;
#(
    parameter int PTR_W     = 10,
    parameter int PTR_MAX   = 782,
    parameter int LOP_INV_N = 8,
    parameter int LOP_NDF_N = 8,
    parameter int CONFIRM_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_stb,
    input  logic [PTR_W-1:0] val,
    input  logic             ndf_on,
    input  logic             is_ais,
    input  logic             in_range,
    input  logic             inc_hit,
    input  logic             dec_hit,
    output logic [PTR_W-1:0] acc,
    output logic             lop,
    output logic [EVW-1:0]   ev
);
    localparam int MAXN = (LOP_INV_N > LOP_NDF_N) ?
                          ((LOP_INV_N > CONFIRM_N) ? LOP_INV_N : CONFIRM_N) :
                          ((LOP_NDF_N > CONFIRM_N) ? LOP_NDF_N : CONFIRM_N);
    localparam int CW = $clog2(MAXN + 1);
    localparam logic [CW-1:0]    INV_LIM = CW'(LOP_INV_N - 1);
    localparam logic [CW-1:0]    NDF_LIM = CW'(LOP_NDF_N - 1);
    localparam logic [CW-1:0]    CNF_LIM = CW'(CONFIRM_N - 1);
    localparam logic [PTR_W-1:0] MAXV    = PTR_W'(PTR_MAX);

    lop_state_e       state_q, state_d;
    logic [PTR_W-1:0] acc_q, acc_d, cand_q, cand_d;
    logic [CW-1:0]    ccnt_q, ccnt_d, icnt_q, icnt_d, ncnt_q, ncnt_d;
    logic             confirm;

    assign acc     = acc_q;
    assign lop     = (state_q == ST_LOSS);
    assign confirm = (val == cand_q) && (ccnt_q == CNF_LIM);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOSS;
            acc_q   <= '0;
            cand_q  <= '0;
            ccnt_q  <= '0;
            icnt_q  <= '0;
            ncnt_q  <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            cand_q  <= cand_d;
            ccnt_q  <= ccnt_d;
            icnt_q  <= icnt_d;
            ncnt_q  <= ncnt_d;
        end
    end

    // next state and events
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        cand_d  = cand_q;
        ccnt_d  = ccnt_q;
        icnt_d  = icnt_q;
        ncnt_d  = ncnt_q;
        ev      = '0;
        if (frm_stb) begin
            unique case (state_q)
                ST_SYNC: begin
                    if (is_ais) begin
                        ev[EV_AIS] = 1'b1;
                        ccnt_d = '0; icnt_d = '0; ncnt_d = '0;
                    end else if (!in_range) begin
                        ev[EV_UNK] = 1'b1;
                        ccnt_d = '0; ncnt_d = '0;
                        icnt_d = icnt_q + 1'b1;
                    end else if (ndf_on) begin
                        ev[EV_NDF] = 1'b1;
                        acc_d  = val;
                        ccnt_d = '0; icnt_d = '0;
                        ncnt_d = ncnt_q + 1'b1;
                    end else if (val == acc_q) begin
                        ccnt_d = '0; icnt_d = '0; ncnt_d = '0;
                    end else if (inc_hit) begin
                        ev[EV_INC] = 1'b1;
                        acc_d  = (acc_q == MAXV) ? '0 : acc_q + 1'b1;
                        ccnt_d = '0; icnt_d = '0; ncnt_d = '0;
                    end else if (dec_hit) begin
                        ev[EV_DEC] = 1'b1;
                        acc_d  = (acc_q == '0) ? MAXV : acc_q - 1'b1;
                        ccnt_d = '0; icnt_d = '0; ncnt_d = '0;
                    end else if (confirm) begin
                        ev[EV_NEW] = 1'b1;
                        acc_d  = val;
                        ccnt_d = '0; icnt_d = '0; ncnt_d = '0;
                    end else begin
                        ev[EV_UNK] = 1'b1;
                        cand_d = val;
                        ccnt_d = (val == cand_q) ? ccnt_q + 1'b1 : CW'(1);
                        ncnt_d = '0;
                        icnt_d = icnt_q + 1'b1;
                    end
                    // transition "declare"
                    if ((ev[EV_UNK] && icnt_q == INV_LIM) ||
                        (ev[EV_NDF] && ncnt_q == NDF_LIM)) begin
                        ev[EV_LOPC] = 1'b1;
                        state_d = ST_LOSS;
                        ccnt_d = '0; icnt_d = '0; ncnt_d = '0;
                    end
                end
                ST_LOSS: begin
                    if (is_ais) begin
                        ev[EV_AIS] = 1'b1;
                        ccnt_d = '0;
                    end else if (!in_range) begin
                        ev[EV_UNK] = 1'b1;
                        ccnt_d = '0;
                    end else if (ndf_on) begin
                        ev[EV_NDF] = 1'b1;
                        ccnt_d = '0;
                    end else if (confirm) begin
                        // transition "confirm"
                        ev[EV_NEW]  = 1'b1;
                        ev[EV_LOPC] = 1'b1;
                        acc_d   = val;
                        state_d = ST_SYNC;
                        ccnt_d = '0; icnt_d = '0; ncnt_d = '0;
                    end else begin
                        ev[EV_UNK] = 1'b1;
                        cand_d = val;
                        ccnt_d = (val == cand_q) ? ccnt_q + 1'b1 : CW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ptr_event_regs.sv
module ptr_event_regs
    import ptr_pkg::*;
#(
    parameter int PTR_W = 10,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVW-1:0]   ev,
    input  logic [EVW-1:0]   ev_mask,
    input  logic             rd_en,
    input  logic             rd_sel,
    input  logic             lop,
    input  logic [PTR_W-1:0] acc,
    output logic [EVW-1:0]   status,
    output logic [DW-1:0]    rd_data,
    output logic             irq
);
    logic rd_clr;

    assign rd_clr = rd_en && !rd_sel;
    assign irq    = |(status & ev_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status  <= '0;
            rd_data <= '0;
        end else begin
            status <= rd_clr ? ev : (status | ev);
            if (rd_en) begin
                rd_data <= '0;
                if (rd_sel) begin
                    rd_data[PTR_W-1:0] <= acc;
                    rd_data[PTR_W]     <= lop;
                end else begin
                    rd_data[EVW-1:0] <= status;
                end
            end
        end
    end
endmodule

// File: rtl/ptr_interp.sv
module ptr_interp
    import ptr_pkg::*;
#(
    parameter int PTR_W     = 10,
    parameter int NDF_W     = 4,
    parameter int SS_W      = 2,
    parameter int PTR_MAX   = 782,
    parameter int LOP_INV_N = 8,
    parameter int LOP_NDF_N = 8,
    parameter int CONFIRM_N = 3,
    parameter int DW        = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frm_stb,
    input  logic [NDF_W+SS_W+PTR_W-1:0] ptr_word,
    input  logic [EVW-1:0]              ev_mask,
    input  logic                        rd_en,
    input  logic                        rd_sel,
    output logic [DW-1:0]               rd_data,
    output logic                        irq
);
    logic             ndf_on_w, ais_w, rng_w, inc_w, dec_w, lop_w;
    logic [PTR_W-1:0] val_w, acc_w;
    logic [EVW-1:0]   ev_w, status_w;

    ptr_word_decode #(
        .PTR_W(PTR_W), .NDF_W(NDF_W), .SS_W(SS_W), .PTR_MAX(PTR_MAX)
    ) i_dec (
        .word(ptr_word), .acc(acc_w), .ndf_on(ndf_on_w), .is_ais(ais_w),
        .in_range(rng_w), .inc_hit(inc_w), .dec_hit(dec_w), .val(val_w)
    );

    ptr_track_fsm #(
        .PTR_W(PTR_W), .PTR_MAX(PTR_MAX), .LOP_INV_N(LOP_INV_N),
        .LOP_NDF_N(LOP_NDF_N), .CONFIRM_N(CONFIRM_N)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .val(val_w),
        .ndf_on(ndf_on_w), .is_ais(ais_w), .in_range(rng_w),
        .inc_hit(inc_w), .dec_hit(dec_w), .acc(acc_w), .lop(lop_w), .ev(ev_w)
    );

    ptr_event_regs #(.PTR_W(PTR_W), .DW(DW)) i_regs (
        .clk(clk), .rst_n(rst_n), .ev(ev_w), .ev_mask(ev_mask),
        .rd_en(rd_en), .rd_sel(rd_sel), .lop(lop_w), .acc(acc_w),
        .status(status_w), .rd_data(rd_data), .irq(irq)
    );
endmodule

// File: rtl/ptr_interp_chk.sv
module ptr_interp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frm_stb,
    input logic [15:0] ptr_word,
    input logic [6:0]  ev_mask,
    input logic        rd_en,
    input logic        rd_sel,
    input logic        irq,
    input logic [6:0]  ev,
    input logic [6:0]  status,
    input logic        lop
);
    logic ndf_like;
    assign ndf_like = ($countones(~(ptr_word[15:12] ^ 4'b1001)) >= 3);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !rd_sel) |=> ((status & $past(status)) == $past(status))); // R1
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && !frm_stb) |=> (status == 7'd0)); // R1
    AST_IRQ_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mask == 7'd0) |-> !irq); // R2
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 7'd0) |-> !irq); // R2
    AST_NDF_NOT_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_stb && ndf_like) |-> !ev[6]); // R3
    AST_AIS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_stb && (&ptr_word)) |=> status[0]); // R6
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev & 7'b1111101)); // R7
    AST_LOP_CHANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (lop != $past(lop)) |-> status[1]); // R9
    AST_QUIET_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |-> (ev == 7'd0)); // R12
endmodule

bind ptr_interp ptr_interp_chk i_chk (
    .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .ptr_word(ptr_word),
    .ev_mask(ev_mask), .rd_en(rd_en), .rd_sel(rd_sel), .irq(irq),
    .ev(ev_w), .status(status_w), .lop(lop_w)
);

// File: tb/test_ptr_interp.sv
`timescale 1ns/1ps
module test_ptr_interp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_stb = 1'b0;
    logic [15:0] ptr_word = '0;
    logic [6:0]  ev_mask = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] v;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 1'b0;

    localparam logic [3:0] NORM = 4'b0110;
    localparam logic [3:0] NDFP = 4'b1001;

    ptr_interp i_ptr_interp (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .ptr_word(ptr_word),
        .ev_mask(ev_mask), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] w(logic [3:0] f, logic [9:0] p);
        return {f, 2'b00, p};
    endfunction

    // monitor: compares read data against the scoreboard
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL %s: got %h expected none", "unexpected read", rd_data);
            end else begin
                e = exp_q.pop_front();
                if (rd_data !== e.v) begin
                    failures++;
                    $display("FAIL %s: got %h expected %h", e.tag, rd_data, e.v);
                end
            end
        end
    end

    task automatic frame(input logic [15:0] wd);
        @(negedge clk);
        frm_stb = 1'b1; ptr_word = wd;
        @(negedge clk);
        frm_stb = 1'b0;
    endtask

    task automatic rd_exp(input logic sel, input logic [15:0] v, input string tag);
        exp_t e;
        @(negedge clk);
        e.v = v; e.tag = tag;
        exp_q.push_back(e);
        rd_en = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic v, input string tag);
        checks++;
        if (irq !== v) begin
            failures++;
            $display("FAIL %s: got %b expected %b", tag, irq, v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        exp_t e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd_exp(1'b0, 16'h0000, "R11 status after reset");
        rd_exp(1'b1, 16'h0400, "R11 loss flag and pointer after reset");
        chk_irq(1'b0, "R11 irq after reset");

        // R10 recovery from the reset loss state
        frame(w(NORM, 10'd100));
        chk_irq(1'b0, "R2 masked status gives no irq");
        rd_exp(1'b0, 16'h0020, "R7 first candidate frame");
        frame(w(NORM, 10'd100));
        rd_exp(1'b0, 16'h0020, "R7 second candidate frame");
        frame(w(NORM, 10'd100));
        rd_exp(1'b0, 16'h0042, "R10 confirm sets new and loss change");
        rd_exp(1'b1, 16'd100, "R10 pointer accepted, flag clear");
        rd_exp(1'b0, 16'h0000, "R1 status cleared by read");

        frame(w(NORM, 10'd100));
        rd_exp(1'b0, 16'h0000, "R12 normal pointer no event");

        ev_mask = 7'h08;
        @(negedge clk);
        chk_irq(1'b0, "R2 no status no irq");
        frame(w(NORM, 10'd100 ^ 10'h2AA));
        chk_irq(1'b1, "R2 enabled increment raises irq");
        rd_exp(1'b0, 16'h0008, "R4 increment all I bits");
        chk_irq(1'b0, "R2 irq drops after read");
        rd_exp(1'b1, 16'd101, "R4 pointer plus one");

        frame(w(NORM, 10'd101 ^ 10'h155));
        rd_exp(1'b0, 16'h0010, "R5 decrement");
        rd_exp(1'b1, 16'd100, "R5 pointer minus one");

        frame(w(NORM, 10'd100 ^ 10'h2A0));
        rd_exp(1'b0, 16'h0008, "R4 increment on 3 of 5 I bits");
        rd_exp(1'b1, 16'd101, "R4 pointer after majority increment");

        frame(w(NDFP, 10'd300));
        rd_exp(1'b0, 16'h0004, "R3 flag with new value, no new bit");
        rd_exp(1'b1, 16'd300, "R3 flag loads pointer");
        frame(w(4'b0001, 10'd300));
        rd_exp(1'b0, 16'h0004, "R3 flag with one bit error");
        frame(w(4'b0000, 10'd300));
        rd_exp(1'b0, 16'h0000, "R3 two bit errors is not a flag");

        frame(16'hFFFF);
        rd_exp(1'b0, 16'h0001, "R6 all ones word");
        rd_exp(1'b1, 16'd300, "R6 pointer unchanged");

        frame(w(NORM, 10'd500));
        rd_exp(1'b0, 16'h0020, "R7 candidate in sync 1");
        frame(w(NORM, 10'd500));
        rd_exp(1'b0, 16'h0020, "R7 candidate in sync 2");
        frame(w(NORM, 10'd500));
        rd_exp(1'b0, 16'h0040, "R7 new pointer confirmed");
        rd_exp(1'b1, 16'd500, "R7 new pointer value");

        frame(w(NORM, 10'd800));
        rd_exp(1'b0, 16'h0020, "R8 value above 782");
        for (int k = 0; k < 6; k++) begin
            frame(w(NORM, 10'd1000));
            rd_exp(1'b0, 16'h0020, "R9 invalid run below limit");
        end
        frame(w(NORM, 10'd1000));
        rd_exp(1'b0, 16'h0022, "R9 eighth invalid declares loss");
        rd_exp(1'b1, 16'h05F4, "R9 loss flag set, pointer kept");

        frame(w(NORM, 10'd782));
        rd_exp(1'b0, 16'h0020, "R8 782 in range, candidate");
        frame(w(NORM, 10'd782));
        rd_exp(1'b0, 16'h0020, "R10 second equal pointer");
        frame(w(NORM, 10'd782));
        rd_exp(1'b0, 16'h0042, "R10 third equal pointer clears loss");
        rd_exp(1'b1, 16'h030E, "R10 pointer 782 accepted");

        for (int k = 0; k < 7; k++) begin
            frame(w(NDFP, 10'd782));
            rd_exp(1'b0, 16'h0004, "R9 flag run below limit");
        end
        frame(w(NDFP, 10'd782));
        rd_exp(1'b0, 16'h0006, "R9 eighth flag declares loss");
        rd_exp(1'b1, 16'h070E, "R9 loss flag after flag run");

        // event in the same cycle as a status read
        frame(16'hFFFF);
        @(negedge clk);
        e.v = 16'h0001; e.tag = "R1 read returns status before event";
        exp_q.push_back(e);
        frm_stb = 1'b1; ptr_word = w(NORM, 10'd782);
        rd_en = 1'b1; rd_sel = 1'b0;
        @(negedge clk);
        frm_stb = 1'b0; rd_en = 1'b0;
        rd_exp(1'b0, 16'h0020, "R1 coinciding event kept");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", "R11 pending reads", exp_q.size(), 0);
        end
        finish_run();
    end
endmodule